// File: doc/BRIEF.md
# Page-Mode DRAM Burst Controller

This block links a host request port to an asynchronous page-mode DRAM with a 64-bit (8-byte) data path. The host gives the address of one 8-byte word. The block splits that address into a row part and a column part. The column part covers one page, and the page size is a parameter. The block remembers which row is held open in the device. A request that falls in the open row goes straight to the column access. A request that falls in another row first pays a miss penalty, during which the row strobe is released. The new row is then opened.

Each request is either one access or a four-beat burst. A burst visits four adjacent words that lie inside an aligned group of four columns. Each beat is paced by a cycle counter. The first beat pays the full access time. The later beats of a burst use a shorter count. A pace-mode input can force every beat to the full access time. The block drives a multiplexed device address and active-low row and column strobes. It pulses a beat-done flag once per finished beat, together with the word address of that beat.

Top module: `pgdram_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, no row is open: `dram_ras_n`=1, `dram_cas_n`=1, `beat_valid`=0 and `req_ready`=1.
- R2: The word address splits into column = low COL_W bits, with COL_W = log2(PAGE_BYTES/8), and row = the remaining upper bits. In the first access cycle after a miss penalty, `dram_ma` carries the row. In every beat cycle it carries that beat's column.
- R3: If the request's row equals the open row (a page hit), the first beat completes FIRST_CYC cycles after acceptance. The acceptance edge is cycle 0, and the beat is signalled in the FIRST_CYC-th cycle after it.
- R4: If no row is open or the row differs (a page miss, which includes the first request after reset), the first beat completes MISS_CYC+FIRST_CYC cycles after acceptance.
- R5: With `uniform_pace`=0 when the request is accepted, beats 2 to 4 of a burst each complete NEXT_CYC cycles after the previous beat.
- R6: With `uniform_pace`=1 when the request is accepted, every beat of a burst completes FIRST_CYC cycles after the previous one. The input is only sampled at acceptance.
- R7: Burst beat k (k=0..3) uses column {col[COL_W-1:2], (col[1:0]+k) mod 4} in the same row. `beat_word` is {row, that column}.
- R8: A request with `req_burst`=0 yields exactly one beat. After the last beat of any request, `req_ready` returns in the next cycle.
- R9: Between requests, `dram_ras_n` stays 0 while a row is open.
- R10: `req_ready` is high only while idle. `beat_valid` is never high together with `req_ready`. `dram_cas_n` is 0 exactly in the cycles where `beat_valid` is 1.
- R11: During the miss penalty, `dram_ras_n` and `dram_cas_n` are both 1. `dram_ras_n` rises only in the cycle after a missing request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request taken at this edge |
| req_burst | input | 1 | 1 = four-beat burst, 0 = single access |
| req_addr | input | ADDR_W | Word address (8-byte units) |
| uniform_pace | input | 1 | 1 = every beat pays the full access count |
| dram_ma | output | MA_W | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| beat_valid | output | 1 | One-cycle pulse per completed beat |
| beat_word | output | ADDR_W | Word address of the completed beat |

## Verification
The page-hit decision for a new request can fall in the same cycle as the end of the previous request, namely the first idle cycle after that request's last beat. In that cycle the compare must already see the row that a preceding miss has just opened. The bench provokes this by offering every next request in exactly that first ready cycle, sweeping all rows with a miss burst followed by two hits. It judges the outcome by the first-beat latency, which must be FIRST_CYC rather than MISS_CYC+FIRST_CYC, and by the column wrap of each following burst.

// File: rtl/pgdram_pkg.sv
package pgdram_pkg;

    localparam int unsigned BUS_BYTES   = 8;
    localparam int unsigned BURST_BEATS = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRECH,
        ST_ACCESS
    } ctl_state_e;

    // column lane inside an aligned group of four
    function automatic logic [1:0] wrap_lane(input logic [1:0] base, input logic [1:0] beat);
        return base + beat;
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b, input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pgdram_page.sv
module pgdram_page #(
    parameter int unsigned ROW_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             close_row,
    input  logic             open_new,
    input  logic [ROW_W-1:0] new_row,
    input  logic [ROW_W-1:0] cmp_row,
    output logic             row_open,
    output logic             page_hit
);
    logic [ROW_W-1:0] open_row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_open   <= 1'b0;
            open_row_q <= '0;
        end else if (open_new) begin
            row_open   <= 1'b1;
            open_row_q <= new_row;
        end else if (close_row) begin
            row_open   <= 1'b0;
        end
    end

    assign page_hit = row_open && (open_row_q == cmp_row);

    // R4: a freshly opened row is open in the following cycle
    p_open_after_load_r4: assert property (@(posedge clk) disable iff (rst)
        open_new |=> row_open);

    // R11: closing and opening never requested together
    p_close_open_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(open_new && close_row));

endmodule

// File: rtl/pgdram_timer.sv
module pgdram_timer #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == CNT_W'(1));

    // R5: every loaded interval is at least one cycle long
    p_load_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
        load |-> (load_val != '0));

    // R3: a load is only issued when the running interval ends or none runs
    p_load_at_end_r3: assert property (@(posedge clk) disable iff (rst)
        load |-> (cnt_q <= CNT_W'(1)));

endmodule

// File: rtl/pgdram_ctrl.sv
module pgdram_ctrl
    import pgdram_pkg::*;
#(
    parameter int unsigned ADDR_W     = 13,
    parameter int unsigned PAGE_BYTES = 512,
    parameter int unsigned FIRST_CYC  = 5,
    parameter int unsigned NEXT_CYC   = 3,
    parameter int unsigned MISS_CYC   = 2,
    localparam int unsigned COL_W     = $clog2(PAGE_BYTES / BUS_BYTES),
    localparam int unsigned ROW_W     = ADDR_W - COL_W,
    localparam int unsigned MA_W      = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_burst,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              uniform_pace,
    output logic [MA_W-1:0]   dram_ma,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              beat_valid,
    output logic [ADDR_W-1:0] beat_word
);
    localparam int unsigned CYC_MAX = max3(FIRST_CYC, NEXT_CYC, MISS_CYC);
    localparam int unsigned CNT_W   = $clog2(CYC_MAX + 1);
    localparam logic [CNT_W-1:0] L_FIRST = CNT_W'(FIRST_CYC);
    localparam logic [CNT_W-1:0] L_NEXT  = CNT_W'(NEXT_CYC);
    localparam logic [CNT_W-1:0] L_MISS  = CNT_W'(MISS_CYC);

    ctl_state_e       state_q;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic             burst_q;
    logic             pace_q;
    logic [1:0]       beat_q;
    logic             row_phase_q;

    logic [ROW_W-1:0] req_row;
    logic [COL_W-1:0] req_col;
    logic [COL_W-1:0] cur_col;
    logic             accept;
    logic             more_beats;
    logic             page_hit;
    logic             row_open;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_last;

    assign req_col = req_addr[COL_W-1:0];
    assign req_row = req_addr[ADDR_W-1:COL_W];

    assign req_ready  = (state_q == ST_IDLE);
    assign accept     = req_ready && req_valid;
    assign more_beats = burst_q && (beat_q != 2'(BURST_BEATS - 1));

    assign cur_col = {col_q[COL_W-1:2], wrap_lane(col_q[1:0], beat_q)};

    pgdram_page #(.ROW_W(ROW_W)) u_page (
        .clk      (clk),
        .rst      (rst),
        .close_row(accept && !page_hit),
        .open_new ((state_q == ST_PRECH) && t_last),
        .new_row  (row_q),
        .cmp_row  (req_row),
        .row_open (row_open),
        .page_hit (page_hit)
    );

    always_comb begin
        t_load = 1'b0;
        t_val  = L_FIRST;
        unique case (state_q)
            ST_IDLE: begin
                t_load = req_valid;
                t_val  = page_hit ? L_FIRST : L_MISS;
            end
            ST_PRECH: begin
                t_load = t_last;
                t_val  = L_FIRST;
            end
            ST_ACCESS: begin
                t_load = t_last && more_beats;
                t_val  = pace_q ? L_FIRST : L_NEXT;
            end
            default: begin
                t_load = 1'b0;
                t_val  = L_FIRST;
            end
        endcase
    end

    pgdram_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (t_load),
        .load_val(t_val),
        .last    (t_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            row_q       <= '0;
            col_q       <= '0;
            burst_q     <= 1'b0;
            pace_q      <= 1'b0;
            beat_q      <= '0;
            row_phase_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    row_q   <= req_row;
                    col_q   <= req_col;
                    burst_q <= req_burst;
                    pace_q  <= uniform_pace;
                    beat_q  <= '0;
                    state_q <= page_hit ? ST_ACCESS : ST_PRECH;
                end
                ST_PRECH: if (t_last) begin
                    state_q     <= ST_ACCESS;
                    row_phase_q <= 1'b1;
                end
                ST_ACCESS: begin
                    row_phase_q <= 1'b0;
                    if (t_last) begin
                        if (more_beats)
                            beat_q <= beat_q + 2'd1;
                        else
                            state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign beat_valid = (state_q == ST_ACCESS) && t_last;
    assign dram_cas_n = !beat_valid;
    assign dram_ras_n = !row_open;
    assign beat_word  = {row_q, cur_col};
    assign dram_ma    = ((state_q == ST_PRECH) || (row_phase_q && !t_last))
                        ? MA_W'(row_q) : MA_W'(cur_col);

    // R1: the controller is idle straight after reset
    p_ready_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (req_ready && dram_ras_n));

    // R10: no beat completes while idle
    p_no_beat_idle_r10: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !beat_valid);

    // R2: a column strobe only occurs under an open row
    p_cas_under_ras_r2: assert property (@(posedge clk) disable iff (rst)
        !dram_cas_n |-> !dram_ras_n);

    // R11: the row strobe is released only right after a missing request is taken
    p_ras_rise_on_miss_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(dram_ras_n) |-> $past(accept));

    // R8: a single access ends after its one beat
    p_single_ends_r8: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && !burst_q) |=> req_ready);

endmodule

// File: tb/test_pgdram_ctrl.sv
module test_pgdram_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 7;
    localparam int PAGE_BYTES = 64;
    localparam int COL        = 3;
    localparam int ROWS       = 16;
    localparam int FIRST      = 5;
    localparam int NEXT       = 3;
    localparam int MISS       = 2;
    localparam int MA_W       = 4;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic              rst;
    logic              req_valid;
    logic              req_ready;
    logic              req_burst;
    logic [ADDR_W-1:0] req_addr;
    logic              uniform_pace;
    logic [MA_W-1:0]   dram_ma;
    logic              dram_ras_n;
    logic              dram_cas_n;
    logic              beat_valid;
    logic [ADDR_W-1:0] beat_word;

    pgdram_ctrl #(
        .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES),
        .FIRST_CYC(FIRST), .NEXT_CYC(NEXT), .MISS_CYC(MISS)
    ) i_pgdram_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_burst(req_burst),
        .req_addr(req_addr), .uniform_pace(uniform_pace),
        .dram_ma(dram_ma), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .beat_valid(beat_valid), .beat_word(beat_word)
    );

    int checks = 0;
    int fails  = 0;
    bit m_vld  = 1'b0;
    int m_row  = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the negedge of the first idle cycle
    task automatic do_req(input int row, input int col, input bit burst, input bit pace);
        bit miss;
        int lat0, step, nb, cyc, got, expc, expw;
        miss = !m_vld || (m_row != row);
        lat0 = (miss ? MISS : 0) + FIRST;
        step = pace ? FIRST : NEXT;
        nb   = burst ? 4 : 1;
        while (!req_ready) @(negedge clk);
        req_valid    = 1'b1;
        req_addr     = ADDR_W'((row << COL) | col);
        req_burst    = burst;
        uniform_pace = pace;
        @(negedge clk);
        req_valid    = 1'b0;
        uniform_pace = !pace;
        cyc = 1;
        got = 0;
        forever begin
            if (miss && cyc == 1) begin
                check(dram_ras_n == 1'b1, "R11 ras_n in miss penalty", int'(dram_ras_n), 1);
                check(dram_cas_n == 1'b1, "R11 cas_n in miss penalty", int'(dram_cas_n), 1);
            end
            if (miss && cyc == MISS + 1)
                check(int'(dram_ma) == row, "R2 row on ma", int'(dram_ma), row);
            check(dram_cas_n == !beat_valid, "R10 cas_n vs beat", int'(dram_cas_n), int'(!beat_valid));
            if (beat_valid) begin
                expc = (col & ~3) | ((col + got) & 3);
                expw = (row << COL) | expc;
                if (got == 0)
                    check(cyc == lat0, miss ? "R4 miss first beat" : "R3 hit first beat", cyc, lat0);
                else
                    check(cyc == lat0 + got * step, pace ? "R6 full-pace beat" : "R5 short beat",
                          cyc, lat0 + got * step);
                check(int'(beat_word) == expw, burst ? "R7 burst word" : "R2 single word",
                      int'(beat_word), expw);
                check(int'(dram_ma) == expc, "R2 column on ma", int'(dram_ma), expc);
                got++;
            end
            if (got == nb) break;
            if (cyc > 80) begin
                check(1'b0, "R8 beats missing", got, nb);
                break;
            end
            @(negedge clk);
            cyc++;
        end
        @(negedge clk);
        check(req_ready == 1'b1, "R8 ready after last beat", int'(req_ready), 1);
        check(beat_valid == 1'b0, "R10 no extra beat", int'(beat_valid), 0);
        check(dram_ras_n == 1'b0, "R9 row held open", int'(dram_ras_n), 0);
        m_vld = 1'b1;
        m_row = row;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        req_valid = 1'b0;
        req_burst = 1'b0;
        req_addr = '0;
        uniform_pace = 1'b0;
        repeat (3) @(negedge clk);
        check(dram_ras_n == 1'b1 && dram_cas_n == 1'b1, "R1 strobes in reset", int'(dram_ras_n), 1);
        rst = 1'b0;
        check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        check(beat_valid == 1'b0, "R1 no beat after reset", int'(beat_valid), 0);
        check(dram_ras_n == 1'b1, "R1 no row open", int'(dram_ras_n), 1);

        for (int r = 0; r < ROWS; r++) begin
            do_req(r, (r * 3) % 8, 1'b1, bit'((r >> 1) & 1));
            do_req(r, (r * 5 + 1) % 8, 1'b0, bit'(r & 1));
            do_req(r, (r + 2) % 8, 1'b1, !bit'((r >> 1) & 1));
        end
        do_req(ROWS - 1, 7, 1'b0, 1'b1);
        do_req(0, 6, 1'b1, 1'b0);
        do_req(0, 1, 1'b1, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule